// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block watches two independent memory ports, a left port and a right port, each presenting a chip enable, a word address and a write strobe every clock cycle. When both ports select the same word, it decides which port reached that word first. The other port is flagged busy. While a port is flagged, its write is kept away from the storage array and its read data is marked as not yet valid. The array, the data path and the pad drivers live outside this block. It only produces per-port busy flags, write grants and read-valid qualifiers.

A strap input chooses the role of the unit. As a master (strap = 1) it arbitrates and drives its busy flags out. As a slave (strap = 0) its own arbitration is idle and its busy outputs stay low. The busy flags of a master are wired to the busy inputs of one or more slaves, which then gate their local writes and reads from those inputs. This lets several units serve a wider word while a single arbiter decides contention. A slave also holds off a port's write until that port's enable and address have been steady for a parameterised number of cycles, so the master's decision has time to arrive.

Top module: `dp_contention_arb`

## Requirements
- R1: A contention exists only when both chip enables are 1 and both addresses are equal. Without it, no busy flag is raised.
- R2: In master mode, the port whose selection (enable rising, or address changing while enabled) is older keeps access, and the other port becomes the loser. When both selections are new in the same cycle, the left port wins. The two busy outputs are never 1 together.
- R3: A busy output returns to 0 on the clock edge that follows the first cycle in which the contention is gone, whether the addresses differ or an enable is low.
- R4: The loser's busy output rises after ADDR_LAT rising edges when the contention began through an address change. It rises after CE_LAT edges when either enable rose in the cycle the contention began. Both latencies default to 1.
- R5: In master mode, the write grant is chip enable AND write strobe AND NOT (busy output OR losing the contention in the current cycle). The loser's write is therefore refused from the first contention cycle.
- R6: The read-valid output is chip enable AND NOT write strobe AND NOT the same blocking term that gates the write grant.
- R7: In slave mode (strap 0), both busy outputs are 0 from the edge after the strap is seen low. Each port is blocked while its busy input is 1.
- R8: In slave mode, a port is also blocked until its enable and address have held their values for more than SLV_HOLD consecutive cycles, with the cycle of a change counting as the first. SLV_HOLD defaults to 1, so a grant is first possible in the second steady cycle.
- R9: During and directly after reset, both busy outputs are 0 and no port owns a contention. The first contention after reset is decided as a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | Role strap: 1 arbitrates locally, 0 obeys busy inputs |
| l_ce | input | 1 | Left port chip enable, active high |
| l_we | input | 1 | Left port write strobe, active high |
| l_addr | input | ADDR_W | Left port word address |
| r_ce | input | 1 | Right port chip enable, active high |
| r_we | input | 1 | Right port write strobe, active high |
| r_addr | input | ADDR_W | Right port word address |
| l_busy_i | input | 1 | Left busy from a master, used in slave mode |
| r_busy_i | input | 1 | Right busy from a master, used in slave mode |
| l_busy_o | output | 1 | Left busy flag, driven in master mode |
| r_busy_o | output | 1 | Right busy flag, driven in master mode |
| l_wgrant | output | 1 | Left write enable toward the array |
| r_wgrant | output | 1 | Right write enable toward the array |
| l_rvalid | output | 1 | Left read data is valid |
| r_rvalid | output | 1 | Right read data is valid |

## Verification
The stimulus covers the following cases, each of which separates a distinct decision:
- Contention begun by the right port moving its address onto a word the left port already holds. This tells the winner choice and the address-path latency apart from the enable path.
- Contention begun by the left port raising its enable onto a word the right port already holds. This exercises the longer enable-path latency and a right-side win.
- Both ports arriving together. This isolates the left-first tie-break.
- Matching addresses with one enable low. This shows that no contention is raised.
- Releases by address change and by enable drop. These check the one-edge clearing.
- A slave phase with toggled busy inputs and fresh addresses. This separates blocking by the external busy from blocking by the settle window.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'b00,
      OWN_LEFT  = 2'b01,
      OWN_RIGHT = 2'b10
   } dpc_owner_e;

   localparam int unsigned DPC_NPORT = 2;
   localparam int unsigned DPC_LEFT  = 0;
   localparam int unsigned DPC_RIGHT = 1;

endpackage

// File: rtl/dpc_port_track.sv
// Per-port selection history: detects a new selection, an enable rise,
// and counts how long the selection has been steady.
module dpc_port_track #(
   parameter int unsigned ADDR_W = 14,
   parameter int unsigned HOLD   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic [ADDR_W-1:0] addr,
   output logic              fresh,
   output logic              ce_rose,
   output logic              held_ok
);

   logic              ce_q;
   logic [ADDR_W-1:0] addr_q;
   logic              addr_moved;
   logic              changed;

   always_comb begin
      addr_moved = (addr != addr_q);
      changed    = (ce != ce_q) || addr_moved;
      fresh      = ce && (!ce_q || addr_moved);
      ce_rose    = ce && !ce_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_q   <= 1'b0;
         addr_q <= '0;
      end else begin
         ce_q   <= ce;
         addr_q <= addr;
      end
   end

   generate
      if (HOLD == 0) begin : g_nohold
         assign held_ok = 1'b1;
         logic unused_chg;
         assign unused_chg = changed;
      end else begin : g_hold
         localparam int unsigned HSAT = HOLD + 1;
         localparam int unsigned HC_W = $clog2(HSAT + 1);
         logic [HC_W-1:0] hcnt_q;
         logic [HC_W-1:0] hcnt_d;

         always_comb begin
            if (changed)                       hcnt_d = HC_W'(1);
            else if (hcnt_q >= HC_W'(HSAT))    hcnt_d = HC_W'(HSAT);
            else                               hcnt_d = hcnt_q + 1'b1;
         end

         assign held_ok = (hcnt_d > HC_W'(HOLD));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hcnt_q <= '0;
            else        hcnt_q <= hcnt_d;
         end
      end
   endgenerate

endmodule

// File: rtl/dpc_arb_core.sv
// Ownership and busy generation for the master role.
module dpc_arb_core
   import dpc_pkg::*;
#(
   parameter int unsigned ADDR_LAT = 1,
   parameter int unsigned CE_LAT   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic master_en,
   input  logic match,
   input  logic l_fresh,
   input  logic r_fresh,
   input  logic ce_path,
   output logic l_busy,
   output logic r_busy,
   output logic l_pend,
   output logic r_pend
);

   localparam int unsigned MAXLAT = (ADDR_LAT > CE_LAT) ? ADDR_LAT : CE_LAT;
   localparam int unsigned CNT_W  = $clog2(MAXLAT + 1);

   dpc_owner_e       owner_q;
   dpc_owner_e       win;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] start_lat;
   logic             lb_q;
   logic             rb_q;

   always_comb begin
      if (owner_q != OWN_NONE)         win = owner_q;
      else if (l_fresh && !r_fresh)    win = OWN_RIGHT;
      else                             win = OWN_LEFT;
      start_lat = ce_path ? CNT_W'(CE_LAT) : CNT_W'(ADDR_LAT);
      l_pend    = master_en && match && (win == OWN_RIGHT);
      r_pend    = master_en && match && (win == OWN_LEFT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_NONE;
         cnt_q   <= '0;
         lb_q    <= 1'b0;
         rb_q    <= 1'b0;
      end else if (!master_en || !match) begin
         owner_q <= OWN_NONE;
         cnt_q   <= '0;
         lb_q    <= 1'b0;
         rb_q    <= 1'b0;
      end else if (owner_q == OWN_NONE) begin
         owner_q <= win;
         if (start_lat == CNT_W'(1)) begin
            lb_q <= (win == OWN_RIGHT);
            rb_q <= (win == OWN_LEFT);
         end else begin
            cnt_q <= start_lat - 1'b1;
         end
      end else if (!lb_q && !rb_q) begin
         if (cnt_q == CNT_W'(1)) begin
            lb_q <= (owner_q == OWN_RIGHT);
            rb_q <= (owner_q == OWN_LEFT);
         end
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign l_busy = lb_q;
   assign r_busy = rb_q;

endmodule

// File: rtl/dpc_port_gate.sv
// Per-port qualification of writes and reads.
module dpc_port_gate (
   input  logic master_en,
   input  logic ce,
   input  logic we,
   input  logic busy_loc,
   input  logic pend_loc,
   input  logic busy_ext,
   input  logic held_ok,
   output logic wgrant,
   output logic rvalid
);

   logic blocked;

   always_comb begin
      blocked = master_en ? (busy_loc || pend_loc) : (busy_ext || !held_ok);
      wgrant  = ce && we && !blocked;
      rvalid  = ce && !we && !blocked;
   end

endmodule

// File: rtl/dp_contention_arb.sv
module dp_contention_arb
   import dpc_pkg::*;
#(
   parameter int unsigned ADDR_W   = 14,
   parameter int unsigned ADDR_LAT = 1,
   parameter int unsigned CE_LAT   = 1,
   parameter int unsigned SLV_HOLD = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              l_ce,
   input  logic              l_we,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_ce,
   input  logic              r_we,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_busy_i,
   input  logic              r_busy_i,
   output logic              l_busy_o,
   output logic              r_busy_o,
   output logic              l_wgrant,
   output logic              r_wgrant,
   output logic              l_rvalid,
   output logic              r_rvalid
);

   generate
      if (ADDR_W < 1) begin : g_bad_aw
         $error("dp_contention_arb: ADDR_W must be at least 1");
      end
      if (ADDR_LAT < 1 || CE_LAT < 1) begin : g_bad_lat
         $error("dp_contention_arb: latencies must be at least 1");
      end
   endgenerate

   logic [DPC_NPORT-1:0] ce_v, we_v, fresh_v, rose_v, held_v;
   logic [DPC_NPORT-1:0] busy_loc, pend_loc, busy_ext, wg_v, rv_v;
   logic [ADDR_W-1:0]    addr_v [DPC_NPORT];
   logic                 match;
   logic                 ce_path;

   assign ce_v[DPC_LEFT]      = l_ce;
   assign ce_v[DPC_RIGHT]     = r_ce;
   assign we_v[DPC_LEFT]      = l_we;
   assign we_v[DPC_RIGHT]     = r_we;
   assign addr_v[DPC_LEFT]    = l_addr;
   assign addr_v[DPC_RIGHT]   = r_addr;
   assign busy_ext[DPC_LEFT]  = l_busy_i;
   assign busy_ext[DPC_RIGHT] = r_busy_i;

   assign match   = ce_v[DPC_LEFT] && ce_v[DPC_RIGHT] &&
                    (addr_v[DPC_LEFT] == addr_v[DPC_RIGHT]);
   assign ce_path = |rose_v;

   generate
      for (genvar p = 0; p < DPC_NPORT; p++) begin : g_port
         dpc_port_track #(
            .ADDR_W (ADDR_W),
            .HOLD   (SLV_HOLD)
         ) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .ce      (ce_v[p]),
            .addr    (addr_v[p]),
            .fresh   (fresh_v[p]),
            .ce_rose (rose_v[p]),
            .held_ok (held_v[p])
         );

         dpc_port_gate u_gate (
            .master_en (master_mode),
            .ce        (ce_v[p]),
            .we        (we_v[p]),
            .busy_loc  (busy_loc[p]),
            .pend_loc  (pend_loc[p]),
            .busy_ext  (busy_ext[p]),
            .held_ok   (held_v[p]),
            .wgrant    (wg_v[p]),
            .rvalid    (rv_v[p])
         );
      end
   endgenerate

   dpc_arb_core #(
      .ADDR_LAT (ADDR_LAT),
      .CE_LAT   (CE_LAT)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_en (master_mode),
      .match     (match),
      .l_fresh   (fresh_v[DPC_LEFT]),
      .r_fresh   (fresh_v[DPC_RIGHT]),
      .ce_path   (ce_path),
      .l_busy    (busy_loc[DPC_LEFT]),
      .r_busy    (busy_loc[DPC_RIGHT]),
      .l_pend    (pend_loc[DPC_LEFT]),
      .r_pend    (pend_loc[DPC_RIGHT])
   );

   assign l_busy_o = busy_loc[DPC_LEFT];
   assign r_busy_o = busy_loc[DPC_RIGHT];
   assign l_wgrant = wg_v[DPC_LEFT];
   assign r_wgrant = wg_v[DPC_RIGHT];
   assign l_rvalid = rv_v[DPC_LEFT];
   assign r_rvalid = rv_v[DPC_RIGHT];

endmodule

// File: rtl/dp_contention_arb_chk.sv
module dp_contention_arb_chk #(
   parameter int unsigned ADDR_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_mode,
   input logic              l_ce,
   input logic              l_we,
   input logic [ADDR_W-1:0] l_addr,
   input logic              r_ce,
   input logic              r_we,
   input logic [ADDR_W-1:0] r_addr,
   input logic              l_busy_i,
   input logic              r_busy_i,
   input logic              l_busy_o,
   input logic              r_busy_o,
   input logic              l_wgrant,
   input logic              r_wgrant,
   input logic              l_rvalid,
   input logic              r_rvalid
);

   logic same_word;
   assign same_word = l_ce && r_ce && (l_addr == r_addr);

   AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (l_busy_o || r_busy_o) |-> $past(same_word));                    // R1
   AST_SINGLE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
      !(l_busy_o && r_busy_o));                                         // R2
   AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      !same_word |=> (!l_busy_o && !r_busy_o));                         // R3
   AST_LBUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && l_busy_o) |-> !l_wgrant);                         // R5
   AST_RBUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && r_busy_o) |-> !r_wgrant);                         // R5
   AST_BUSY_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && (l_busy_o || r_busy_o)) |-> !(l_busy_o && l_rvalid) && !(r_busy_o && r_rvalid)); // R6
   AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |=> (!l_busy_o && !r_busy_o));                       // R7
   AST_SLAVE_OBEYS: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> !(l_busy_i && (l_wgrant || l_rvalid)) && !(r_busy_i && (r_wgrant || r_rvalid))); // R7

endmodule

bind dp_contention_arb dp_contention_arb_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dp_contention_arb_tb.sv
`timescale 1ns/1ps
module dp_contention_arb_tb;

   localparam int AW    = 8;
   localparam int A_LAT = 1;
   localparam int C_LAT = 2;
   localparam int HOLD  = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_mode = 1'b1;
   logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic l_busy_i = 0, r_busy_i = 0;
   logic l_busy_o, r_busy_o, l_wgrant, r_wgrant, l_rvalid, r_rvalid;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   string phase = "R9 reset";

   always #10 clk = ~clk;

   dp_contention_arb #(
      .ADDR_W(AW), .ADDR_LAT(A_LAT), .CE_LAT(C_LAT), .SLV_HOLD(HOLD)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
      .l_ce(l_ce), .l_we(l_we), .l_addr(l_addr),
      .r_ce(r_ce), .r_we(r_we), .r_addr(r_addr),
      .l_busy_i(l_busy_i), .r_busy_i(r_busy_i),
      .l_busy_o(l_busy_o), .r_busy_o(r_busy_o),
      .l_wgrant(l_wgrant), .r_wgrant(r_wgrant),
      .l_rvalid(l_rvalid), .r_rvalid(r_rvalid)
   );

   // Reference model state (owner: 0 none, 1 left kept access, 2 right kept access)
   int m_lce_p = 0, m_rce_p = 0, m_la_p = 0, m_ra_p = 0;
   int m_own = 0, m_wait = 0, m_lb = 0, m_rb = 0, m_lh = 0, m_rh = 0;

   function automatic int same_word();
      return (l_ce && r_ce && (l_addr == r_addr)) ? 1 : 0;
   endfunction

   function automatic int winner();
      int lnew, rnew;
      if (m_own != 0) return m_own;
      lnew = (l_ce && (m_lce_p == 0 || int'(l_addr) != m_la_p)) ? 1 : 0;
      rnew = (r_ce && (m_rce_p == 0 || int'(r_addr) != m_ra_p)) ? 1 : 0;
      if (lnew == 1 && rnew == 0) return 2;
      return 1;
   endfunction

   function automatic int steady(int ce, int ce_p, int a, int a_p, int h);
      if (ce != ce_p || a != a_p) return 1;
      if (h >= HOLD + 1) return HOLD + 1;
      return h + 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_lce_p = 0; m_rce_p = 0; m_la_p = 0; m_ra_p = 0;
         m_own = 0; m_wait = 0; m_lb = 0; m_rb = 0; m_lh = 0; m_rh = 0;
      end else begin
         int w, lat;
         w = winner();
         if (!master_mode || same_word() == 0) begin
            m_own = 0; m_wait = 0; m_lb = 0; m_rb = 0;
         end else if (m_own == 0) begin
            m_own = w;
            lat = (m_lce_p == 0 || m_rce_p == 0) ? C_LAT : A_LAT;
            m_wait = lat - 1;
            if (m_wait == 0) begin m_lb = (w == 2); m_rb = (w == 1); end
         end else if (m_lb == 0 && m_rb == 0) begin
            m_wait = m_wait - 1;
            if (m_wait == 0) begin m_lb = (m_own == 2); m_rb = (m_own == 1); end
         end
         m_lh = steady(int'(l_ce), m_lce_p, int'(l_addr), m_la_p, m_lh);
         m_rh = steady(int'(r_ce), m_rce_p, int'(r_addr), m_ra_p, m_rh);
         m_lce_p = int'(l_ce); m_rce_p = int'(r_ce);
         m_la_p = int'(l_addr); m_ra_p = int'(r_addr);
      end
   end

   task automatic check(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      int w, m, lblk, rblk, lh, rh;
      w = winner();
      m = same_word();
      if (master_mode) begin
         lblk = (m_lb == 1 || (m == 1 && w == 2)) ? 1 : 0;
         rblk = (m_rb == 1 || (m == 1 && w == 1)) ? 1 : 0;
      end else begin
         lh = steady(int'(l_ce), m_lce_p, int'(l_addr), m_la_p, m_lh);
         rh = steady(int'(r_ce), m_rce_p, int'(r_addr), m_ra_p, m_rh);
         lblk = (l_busy_i || lh <= HOLD) ? 1 : 0;
         rblk = (r_busy_i || rh <= HOLD) ? 1 : 0;
      end
      check(phase, "l_busy_o", int'(l_busy_o), m_lb);
      check(phase, "r_busy_o", int'(r_busy_o), m_rb);
      check(phase, "l_wgrant", int'(l_wgrant), (l_ce && l_we && lblk == 0) ? 1 : 0);
      check(phase, "r_wgrant", int'(r_wgrant), (r_ce && r_we && rblk == 0) ? 1 : 0);
      check(phase, "l_rvalid", int'(l_rvalid), (l_ce && !l_we && lblk == 0) ? 1 : 0);
      check(phase, "r_rvalid", int'(r_rvalid), (r_ce && !r_we && rblk == 0) ? 1 : 0);
   endtask

   always @(negedge clk) begin
      #5;
      if (rst_n) compare_model();
   end

   task automatic drive(input logic lc, input logic lw, input int la,
                        input logic rc, input logic rw, input int ra);
      @(negedge clk);
      l_ce = lc; l_we = lw; l_addr = AW'(la);
      r_ce = rc; r_we = rw; r_addr = AW'(ra);
      #5;
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected<5000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #3;
      check("R9", "busy_l in reset", int'(l_busy_o), 0);
      check("R9", "busy_r in reset", int'(r_busy_o), 0);
      @(negedge clk); rst_n = 1'b1;
      #5;
      check("R9", "busy_l after reset", int'(l_busy_o), 0);

      phase = "R1 distinct words";
      drive(1, 1, 5, 1, 1, 9);
      drive(1, 1, 5, 1, 1, 9);
      check("R1", "l_wgrant distinct", int'(l_wgrant), 1);
      check("R1", "r_wgrant distinct", int'(r_wgrant), 1);
      check("R1", "no busy distinct", int'(l_busy_o | r_busy_o), 0);

      phase = "R2 R4 R5 right moves onto left word";
      drive(1, 1, 5, 1, 1, 5);
      check("R5", "loser write refused first cycle", int'(r_wgrant), 0);
      check("R2", "older left keeps write", int'(l_wgrant), 1);
      check("R4", "busy not yet raised", int'(r_busy_o), 0);
      drive(1, 1, 5, 1, 1, 5);
      check("R4", "right busy after ADDR_LAT", int'(r_busy_o), 1);
      check("R2", "left not busy", int'(l_busy_o), 0);
      drive(1, 1, 5, 1, 1, 5);

      phase = "R3 release by address";
      drive(1, 1, 5, 1, 1, 6);
      drive(1, 1, 5, 1, 1, 6);
      check("R3", "busy cleared after address split", int'(r_busy_o), 0);

      phase = "R2 R4 R6 left enable rises onto right word";
      drive(0, 0, 0, 1, 0, 9);
      drive(0, 0, 0, 1, 0, 9);
      drive(1, 1, 9, 1, 0, 9);
      check("R5", "new left write refused", int'(l_wgrant), 0);
      check("R6", "older right read valid", int'(r_rvalid), 1);
      drive(1, 1, 9, 1, 0, 9);
      check("R4", "enable path not yet busy", int'(l_busy_o), 0);
      drive(1, 1, 9, 1, 0, 9);
      check("R4", "left busy after CE_LAT", int'(l_busy_o), 1);
      drive(1, 0, 9, 1, 0, 9);
      check("R6", "busy left read not valid", int'(l_rvalid), 0);

      phase = "R3 release by enable";
      drive(0, 0, 9, 1, 0, 9);
      drive(0, 0, 9, 1, 0, 9);
      check("R3", "busy cleared after enable drop", int'(l_busy_o), 0);

      phase = "R2 simultaneous arrival";
      drive(0, 0, 0, 0, 0, 0);
      drive(1, 1, 3, 1, 1, 3);
      check("R2", "tie left granted", int'(l_wgrant), 1);
      check("R2", "tie right refused", int'(r_wgrant), 0);
      drive(1, 1, 3, 1, 1, 3);
      drive(1, 1, 3, 1, 1, 3);
      check("R2", "tie right busy", int'(r_busy_o), 1);

      phase = "R1 one enable low";
      drive(0, 0, 7, 0, 0, 7);
      drive(1, 1, 7, 0, 0, 7);
      drive(1, 1, 7, 0, 0, 7);
      drive(1, 1, 7, 0, 0, 7);
      check("R1", "no busy with right disabled", int'(l_busy_o | r_busy_o), 0);
      check("R1", "left write granted", int'(l_wgrant), 1);

      phase = "R7 R8 slave";
      drive(0, 0, 0, 0, 0, 0);
      master_mode = 1'b0;
      drive(1, 1, 2, 1, 1, 2);
      check("R8", "slave write held on change", int'(l_wgrant), 0);
      drive(1, 1, 2, 1, 1, 2);
      check("R8", "slave write after hold", int'(l_wgrant), 1);
      check("R7", "slave matching words no busy out", int'(l_busy_o | r_busy_o), 0);
      @(negedge clk); l_busy_i = 1'b1; #5;
      check("R7", "busy input blocks left", int'(l_wgrant), 0);
      check("R7", "right unaffected", int'(r_wgrant), 1);
      drive(1, 0, 2, 1, 1, 4);
      check("R7", "left read blocked by busy input", int'(l_rvalid), 0);
      @(negedge clk); l_busy_i = 1'b0; r_busy_i = 1'b1; #5;
      check("R7", "left read valid again", int'(l_rvalid), 1);
      check("R7", "right blocked", int'(r_wgrant), 0);
      @(negedge clk); r_busy_i = 1'b0; #5;
      check("R8", "right granted once steady", int'(r_wgrant), 1);
      drive(0, 0, 0, 0, 0, 0);
      finish_run();
   end

endmodule